// File: doc/BRIEF.md
# Vector Register Hazard Scoreboard

This block guards the physical vector registers of one SIMD group against read-after-write and write-after-anything hazards. Each register carries two status bits: a pending bit, raised when an instruction that writes the register is issued, and a busy bit, raised when that instruction starts executing (the pending bit drops on the same edge). An instruction scheduler asks, through a purely combinational query port, whether all vector operands of a candidate instruction are free. Up to `NUM_OPS` operands are checked at once. Register indices arrive already mapped to physical registers.

A busy bit is released in one of two ways. Timed writers arm a release timer at execute, with a latency picked by operand width. Memory loads and atomics are marked deferred. They hold the busy bit until the memory path sends a completion strobe naming the registers and a delay. Timers live in a small slot table. When the table cannot take the releases that an execute or completion needs, the block raises a stall output and ignores that strobe, so no release is ever lost. An operand wider than four bytes covers a register pair, and the pair wraps from the top index to index 0.

The register count must be even and a whole multiple of the allocation granule `MIN_ALLOC`. Otherwise elaboration stops with an error.

Top module: `vreg_scoreboard`

## Requirements
- R1: After reset every register reports ready on the query port, and both blocked-cause counters read zero.
- R2: A query operand with its vector flag set is blocked when the busy bit or the pending bit of any register it covers is set. An operand whose vector flag is clear is never blocked. `q_ready` is 1 only when no operand is blocked, and it is independent of `q_valid`.
- R3: An operand with its wide flag set covers registers idx and (idx+1) mod NUM_REGS. This applies to queries, issue, execute, completion and timer release alike.
- R4: On an edge with `q_valid`=1 and `q_ready`=0, the lowest-numbered blocked operand decides which counter steps by one. `wax_cnt` steps if that operand's destination flag is 1, and `raw_cnt` steps if it is 0. Both counters saturate at all ones.
- R5: An issue strobe sets the pending bit of every register covered by each destination enabled in `iss_dmask`.
- R6: An accepted execute strobe sets the busy bit and clears the pending bit of every covered destination register on the same edge. When a set and a clear meet on the same bit, the set wins.
- R7: A non-deferred accepted execute arms one release timer per destination. Its latency is `SP_LAT` for a narrow operand and `DP_LAT` for a wide one. The busy bits stay set for exactly that many cycles after the execute edge and clear on the following edge.
- R8: A deferred execute arms no timer, and its busy bits stay set until a completion arrives. A completion strobe with delay D (D=0 taken as 1) clears the busy bits of its enabled registers D cycles after the strobe edge. The `cmp_wide` flag applies to every register in the list.
- R9: `ex_stall` is 1 when a non-deferred execute needs more timer slots than remain free after the completion's share. A stalled execute changes no status bit. A deferred execute never stalls.
- R10: If a timer expiry and a new busy set hit the same register on the same edge, the register stays busy.
- R11: `cmp_stall` is 1 when a completion needs more timer slots than are free. A stalled completion is ignored. When both strobes compete for slots, the completion is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | 1 | Query is a real scheduling attempt (enables counting) |
| q_vec | input | NUM_OPS | Per operand: operand is a vector register |
| q_dst | input | NUM_OPS | Per operand: operand is a destination |
| q_wide | input | NUM_OPS | Per operand: operand spans a register pair |
| q_idx | input | NUM_OPS*IDX_W | Per operand physical index, operand o at bits [o*IDX_W +: IDX_W] |
| q_ready | output | 1 | All vector operands free |
| wax_cnt | output | CNT_W | Blocks caused by a destination operand |
| raw_cnt | output | CNT_W | Blocks caused by a source operand |
| iss_valid | input | 1 | Issue strobe |
| iss_dmask | input | NUM_DST | Enabled destinations at issue |
| iss_wide | input | NUM_DST | Wide flag per destination at issue |
| iss_idx | input | NUM_DST*IDX_W | Destination indices at issue |
| ex_valid | input | 1 | Execute strobe |
| ex_deferred | input | 1 | Execute belongs to a load or atomic |
| ex_dmask | input | NUM_DST | Enabled destinations at execute |
| ex_wide | input | NUM_DST | Wide flag per destination at execute |
| ex_idx | input | NUM_DST*IDX_W | Destination indices at execute |
| ex_stall | output | 1 | Execute refused for lack of timer slots |
| cmp_valid | input | 1 | Memory completion strobe |
| cmp_dmask | input | NUM_DST | Enabled entries of the completion list |
| cmp_wide | input | 1 | Operand width for the whole list |
| cmp_idx | input | NUM_DST*IDX_W | Completion register indices |
| cmp_delay | input | DLY_W | Cycles until release |
| cmp_stall | output | 1 | Completion refused for lack of timer slots |

## Verification
The bench builds the block with eight registers, an allocation granule of two, two timer slots, three operands, two destinations and latencies of three and five cycles. With eight registers a wide operand at index 7 lands on the wrap to index 0 within a few cycles. Two slots let a single two-destination execute exhaust the timer table, which exposes both stall outputs and the completion-first sharing. The short, unequal latencies separate narrow from wide releases by cycle count. They also make it cheap to line up a new busy set exactly on a timer's expiry edge.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

    // Which kind of operand stopped an instruction at the query port
    typedef enum logic [1:0] {
        BLK_NONE = 2'd0,
        BLK_RAW  = 2'd1,
        BLK_WAX  = 2'd2
    } blk_cause_e;

    // Release latency selected by operand width
    function automatic int rel_latency(input logic wide, input int sp_lat, input int dp_lat);
        return wide ? dp_lat : sp_lat;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/vsb_pair_mask.sv
// Expands a physical index and a wide flag into a per-register mask;
// the second register of a pair wraps to index 0.
module vsb_pair_mask #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic          en,
    input  logic          wide,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  mask
);
    always_comb begin
        int nxt;
        nxt = (int'(idx) + 1) % N;
        for (int k = 0; k < N; k++) begin
            mask[k] = en && ((k == int'(idx)) || (wide && (k == nxt)));
        end
    end
endmodule

// File: rtl/vsb_ready_check.sv
// Combinational readiness: blocks on any covered busy or pending bit and
// reports the kind of the first blocking operand.
module vsb_ready_check
    import vsb_pkg::*;
#(
    parameter int N      = 64,
    parameter int NOPS   = 3
) (
    input  logic [N-1:0]      status_any,
    input  logic [NOPS*N-1:0] op_mask,
    input  logic [NOPS-1:0]   op_dst,
    output logic              ready,
    output blk_cause_e        cause
);
    logic [NOPS-1:0] blocked;

    for (genvar o = 0; o < NOPS; o++) begin : g_op
        assign blocked[o] = |(op_mask[o*N +: N] & status_any);
    end

    always_comb begin
        logic found;
        found = 1'b0;
        cause = BLK_NONE;
        for (int o = 0; o < NOPS; o++) begin
            if (!found && blocked[o]) begin
                found = 1'b1;
                cause = op_dst[o] ? BLK_WAX : BLK_RAW;
            end
        end
        ready = !found;
    end
endmodule

// File: rtl/vsb_release_timers.sv
// Slot table of release down-counters. Requests are placed in request
// order into the lowest free slots; an expiring slot emits a clear mask.
module vsb_release_timers #(
    parameter int N     = 64,
    parameter int IW    = 6,
    parameter int SLOTS = 8,
    parameter int REQS  = 4,
    parameter int TW    = 8,
    parameter int SW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REQS-1:0]    req_v,
    input  logic [REQS-1:0]    req_wide,
    input  logic [REQS*IW-1:0] req_idx,
    input  logic [REQS*TW-1:0] req_cnt,
    output logic [SW-1:0]      free_cnt,
    output logic [N-1:0]       clr_mask
);
    typedef struct packed {
        logic          valid;
        logic          wide;
        logic [IW-1:0] idx;
        logic [TW-1:0] cnt;
    } slot_t;

    slot_t           slot_q [SLOTS];
    slot_t           slot_d [SLOTS];
    logic [SLOTS-1:0] live;
    logic [SLOTS-1:0] expire;
    logic [SLOTS*N-1:0] slot_mask;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign live[s]   = slot_q[s].valid;
        assign expire[s] = slot_q[s].valid && (slot_q[s].cnt == TW'(1));

        vsb_pair_mask #(.N(N), .IW(IW)) u_mask (
            .en   (expire[s]),
            .wide (slot_q[s].wide),
            .idx  (slot_q[s].idx),
            .mask (slot_mask[s*N +: N])
        );

        // R7: a live slot never holds a zero count
        a_r7_slot_live: assert property (@(posedge clk) disable iff (rst)
            slot_q[s].valid |-> (slot_q[s].cnt != '0));
    end

    always_comb begin
        clr_mask = '0;
        for (int s = 0; s < SLOTS; s++) clr_mask |= slot_mask[s*N +: N];
    end

    assign free_cnt = SW'($countones(~live));

    always_comb begin
        logic [SLOTS-1:0] taken;
        logic placed;
        taken = '0;
        for (int s = 0; s < SLOTS; s++) begin
            slot_d[s] = slot_q[s];
            if (slot_q[s].valid) begin
                if (expire[s]) slot_d[s].valid = 1'b0;
                else           slot_d[s].cnt   = slot_q[s].cnt - TW'(1);
            end
        end
        for (int r = 0; r < REQS; r++) begin
            placed = 1'b0;
            for (int s = 0; s < SLOTS; s++) begin
                if (req_v[r] && !placed && !slot_q[s].valid && !taken[s]) begin
                    taken[s]  = 1'b1;
                    placed    = 1'b1;
                    slot_d[s] = '{valid: 1'b1, wide: req_wide[r],
                                  idx: req_idx[r*IW +: IW], cnt: req_cnt[r*TW +: TW]};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < SLOTS; s++) begin
            if (rst) slot_q[s] <= '0;
            else     slot_q[s] <= slot_d[s];
        end
    end
endmodule

// File: rtl/vreg_scoreboard.sv
module vreg_scoreboard
    import vsb_pkg::*;
#(
    parameter int NUM_REGS  = 64,
    parameter int MIN_ALLOC = 4,
    parameter int NUM_OPS   = 3,
    parameter int NUM_DST   = 2,
    parameter int NUM_SLOTS = 8,
    parameter int SP_LAT    = 4,
    parameter int DP_LAT    = 8,
    parameter int DLY_W     = 6,
    parameter int CNT_W     = 16,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     q_valid,
    input  logic [NUM_OPS-1:0]       q_vec,
    input  logic [NUM_OPS-1:0]       q_dst,
    input  logic [NUM_OPS-1:0]       q_wide,
    input  logic [NUM_OPS*IDX_W-1:0] q_idx,
    output logic                     q_ready,
    output logic [CNT_W-1:0]         wax_cnt,
    output logic [CNT_W-1:0]         raw_cnt,
    input  logic                     iss_valid,
    input  logic [NUM_DST-1:0]       iss_dmask,
    input  logic [NUM_DST-1:0]       iss_wide,
    input  logic [NUM_DST*IDX_W-1:0] iss_idx,
    input  logic                     ex_valid,
    input  logic                     ex_deferred,
    input  logic [NUM_DST-1:0]       ex_dmask,
    input  logic [NUM_DST-1:0]       ex_wide,
    input  logic [NUM_DST*IDX_W-1:0] ex_idx,
    output logic                     ex_stall,
    input  logic                     cmp_valid,
    input  logic [NUM_DST-1:0]       cmp_dmask,
    input  logic                     cmp_wide,
    input  logic [NUM_DST*IDX_W-1:0] cmp_idx,
    input  logic [DLY_W-1:0]         cmp_delay,
    output logic                     cmp_stall
);
    localparam int N     = NUM_REGS;
    localparam int REQS  = 2 * NUM_DST;
    localparam int MAXL  = max3(SP_LAT, DP_LAT, (1 << DLY_W) - 1);
    localparam int TW    = $clog2(MAXL + 1);
    localparam int SW    = $clog2(NUM_SLOTS + 1);

    if (NUM_REGS % 2 != 0) begin : g_err_even
        $error("register count must be even");
    end
    if (NUM_REGS % MIN_ALLOC != 0) begin : g_err_gran
        $error("register count must be a multiple of the allocation granule");
    end
    if (SP_LAT < 1 || DP_LAT < 1) begin : g_err_lat
        $error("release latencies must be at least one cycle");
    end

    logic [N-1:0] busy_q, pend_q;
    logic [N-1:0] busy_set, pend_set, pend_clr, busy_clr;

    // ---------------- query path ----------------
    logic [NUM_OPS*N-1:0] q_mask;
    blk_cause_e           q_cause;

    for (genvar o = 0; o < NUM_OPS; o++) begin : g_qop
        vsb_pair_mask #(.N(N), .IW(IDX_W)) u_qm (
            .en   (q_vec[o]),
            .wide (q_wide[o]),
            .idx  (q_idx[o*IDX_W +: IDX_W]),
            .mask (q_mask[o*N +: N])
        );
    end

    vsb_ready_check #(.N(N), .NOPS(NUM_OPS)) u_ready (
        .status_any (busy_q | pend_q),
        .op_mask    (q_mask),
        .op_dst     (q_dst),
        .ready      (q_ready),
        .cause      (q_cause)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wax_cnt <= '0;
            raw_cnt <= '0;
        end else if (q_valid) begin
            if (q_cause == BLK_WAX && wax_cnt != '1) wax_cnt <= wax_cnt + CNT_W'(1);
            if (q_cause == BLK_RAW && raw_cnt != '1) raw_cnt <= raw_cnt + CNT_W'(1);
        end
    end

    // ---------------- slot arbitration ----------------
    logic [SW-1:0] free_cnt;
    logic          cmp_ok, ex_ok, ex_timed;

    always_comb begin
        int cmp_need, ex_need, avail;
        cmp_need  = cmp_valid ? $countones(cmp_dmask) : 0;
        cmp_stall = cmp_need > int'(free_cnt);
        cmp_ok    = cmp_valid && !cmp_stall;
        avail     = int'(free_cnt) - (cmp_ok ? cmp_need : 0);
        ex_need   = (ex_valid && !ex_deferred) ? $countones(ex_dmask) : 0;
        ex_stall  = ex_need > avail;
        ex_ok     = ex_valid && !ex_stall;
        ex_timed  = ex_ok && !ex_deferred;
    end

    // ---------------- per-destination masks ----------------
    logic [NUM_DST*N-1:0]   iss_m, ex_m;
    logic [REQS-1:0]        rq_v, rq_wide;
    logic [REQS*IDX_W-1:0]  rq_idx;
    logic [REQS*TW-1:0]     rq_cnt;
    logic [TW-1:0]          cmp_cnt;

    assign cmp_cnt = (cmp_delay == '0) ? TW'(1) : TW'(cmp_delay);

    for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
        vsb_pair_mask #(.N(N), .IW(IDX_W)) u_im (
            .en   (iss_valid && iss_dmask[d]),
            .wide (iss_wide[d]),
            .idx  (iss_idx[d*IDX_W +: IDX_W]),
            .mask (iss_m[d*N +: N])
        );
        vsb_pair_mask #(.N(N), .IW(IDX_W)) u_em (
            .en   (ex_ok && ex_dmask[d]),
            .wide (ex_wide[d]),
            .idx  (ex_idx[d*IDX_W +: IDX_W]),
            .mask (ex_m[d*N +: N])
        );
        // completion requests first: they take slots ahead of execute
        assign rq_v[d]                       = cmp_ok && cmp_dmask[d];
        assign rq_wide[d]                    = cmp_wide;
        assign rq_idx[d*IDX_W +: IDX_W]      = cmp_idx[d*IDX_W +: IDX_W];
        assign rq_cnt[d*TW +: TW]            = cmp_cnt;
        assign rq_v[NUM_DST+d]               = ex_timed && ex_dmask[d];
        assign rq_wide[NUM_DST+d]            = ex_wide[d];
        assign rq_idx[(NUM_DST+d)*IDX_W +: IDX_W] = ex_idx[d*IDX_W +: IDX_W];
        assign rq_cnt[(NUM_DST+d)*TW +: TW]  = TW'(rel_latency(ex_wide[d], SP_LAT, DP_LAT));
    end

    always_comb begin
        pend_set = '0;
        busy_set = '0;
        for (int d = 0; d < NUM_DST; d++) begin
            pend_set |= iss_m[d*N +: N];
            busy_set |= ex_m[d*N +: N];
        end
        pend_clr = busy_set;
    end

    vsb_release_timers #(
        .N(N), .IW(IDX_W), .SLOTS(NUM_SLOTS), .REQS(REQS), .TW(TW), .SW(SW)
    ) u_timers (
        .clk      (clk),
        .rst      (rst),
        .req_v    (rq_v),
        .req_wide (rq_wide),
        .req_idx  (rq_idx),
        .req_cnt  (rq_cnt),
        .free_cnt (free_cnt),
        .clr_mask (busy_clr)
    );

    // ---------------- status bits (sets win over clears) ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
            pend_q <= '0;
        end else begin
            busy_q <= (busy_q & ~busy_clr) | busy_set;
            pend_q <= (pend_q & ~pend_clr) | pend_set;
        end
    end

    // ---------------- assertions ----------------
    logic [IDX_W-1:0] iss_idx0, ex_idx0;
    assign iss_idx0 = iss_idx[IDX_W-1:0];
    assign ex_idx0  = ex_idx[IDX_W-1:0];

    a_r5_issue_sets_pend: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_dmask[0]) |=> pend_q[$past(iss_idx0)]);

    a_r6_exec_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && !ex_stall && ex_dmask[0]) |=> busy_q[$past(ex_idx0)]);

    a_r4_wax_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (wax_cnt == $past(wax_cnt)) || (wax_cnt == $past(wax_cnt) + CNT_W'(1)));

    a_r4_raw_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (raw_cnt == $past(raw_cnt)) || (raw_cnt == $past(raw_cnt) + CNT_W'(1)));

    a_r9_stall_only_timed: assert property (@(posedge clk) disable iff (rst)
        ex_stall |-> (ex_valid && !ex_deferred));

    a_r11_cmp_stall_valid: assert property (@(posedge clk) disable iff (rst)
        cmp_stall |-> cmp_valid);
endmodule

// File: tb/tb_vreg_scoreboard.sv
module tb_vreg_scoreboard;
    localparam int NR = 8, NO = 3, ND = 2, IW = 3, SP = 3, DP = 5, DW = 4, CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic q_valid; logic [NO-1:0] q_vec, q_dst, q_wide; logic [NO*IW-1:0] q_idx;
    logic q_ready; logic [CW-1:0] wax_cnt, raw_cnt;
    logic iss_valid; logic [ND-1:0] iss_dmask, iss_wide; logic [ND*IW-1:0] iss_idx;
    logic ex_valid, ex_deferred; logic [ND-1:0] ex_dmask, ex_wide; logic [ND*IW-1:0] ex_idx;
    logic ex_stall;
    logic cmp_valid, cmp_wide; logic [ND-1:0] cmp_dmask; logic [ND*IW-1:0] cmp_idx;
    logic [DW-1:0] cmp_delay; logic cmp_stall;

    vreg_scoreboard #(
        .NUM_REGS(NR), .MIN_ALLOC(2), .NUM_OPS(NO), .NUM_DST(ND), .NUM_SLOTS(2),
        .SP_LAT(SP), .DP_LAT(DP), .DLY_W(DW), .CNT_W(CW)
    ) dut (.*);

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic idle();
        q_valid = 0; q_vec = '0; q_dst = '0; q_wide = '0; q_idx = '0;
        iss_valid = 0; iss_dmask = '0; iss_wide = '0; iss_idx = '0;
        ex_valid = 0; ex_deferred = 0; ex_dmask = '0; ex_wide = '0; ex_idx = '0;
        cmp_valid = 0; cmp_dmask = '0; cmp_wide = 0; cmp_idx = '0; cmp_delay = '0;
    endtask

    task automatic set_op(int o, bit vec, bit dst, bit wide, int idx);
        q_vec[o] = vec; q_dst[o] = dst; q_wide[o] = wide; q_idx[o*IW +: IW] = IW'(idx);
    endtask

    // status probe: single operand, q_valid low so counters stay put
    task automatic probe(string req, int idx, bit wide, int exp_ready);
        q_valid = 0; q_vec = '0; q_dst = '0; q_wide = '0;
        set_op(0, 1, 0, wide, idx);
        #1 chk(req, $sformatf("ready reg %0d wide %0d", idx, wide), int'(q_ready), exp_ready);
        q_vec = '0;
    endtask

    task automatic do_exec(bit defr, logic [1:0] dm, logic [1:0] wd, int i1, int i0);
        ex_valid = 1; ex_deferred = defr; ex_dmask = dm; ex_wide = wd;
        ex_idx = {IW'(i1), IW'(i0)};
    endtask

    task automatic do_cmp(logic [1:0] dm, bit wd, int i1, int i0, int dly);
        cmp_valid = 1; cmp_dmask = dm; cmp_wide = wd; cmp_idx = {IW'(i1), IW'(i0)};
        cmp_delay = DW'(dly);
    endtask

    task automatic t_reset();
        for (int r = 0; r < NR; r++) probe("R1", r, 0, 1);
        chk("R1", "wax after reset", int'(wax_cnt), 0);
        chk("R1", "raw after reset", int'(raw_cnt), 0);
    endtask

    task automatic t_issue_exec_narrow();
        iss_valid = 1; iss_dmask = 2'b01; iss_idx = {IW'(0), IW'(2)};
        tick(); idle();
        probe("R5", 2, 0, 0);
        probe("R2", 3, 0, 1);
        do_exec(0, 2'b01, 2'b00, 0, 2);
        tick(); idle();
        probe("R6", 2, 0, 0);
        repeat (SP-1) tick();
        probe("R7", 2, 0, 0);
        tick();
        probe("R7", 2, 0, 1);
    endtask

    task automatic t_wide_wrap();
        do_exec(0, 2'b01, 2'b01, 0, 7);
        tick(); idle();
        probe("R3", 7, 0, 0);
        probe("R3", 0, 0, 0);
        probe("R3", 1, 0, 1);
        probe("R3", 6, 1, 0);
        probe("R3", 1, 1, 1);
        repeat (DP-1) tick();
        probe("R7", 0, 0, 0);
        tick();
        probe("R7", 7, 1, 1);
    endtask

    task automatic t_deferred();
        do_exec(1, 2'b01, 2'b00, 0, 4);
        tick(); idle();
        repeat (10) tick();
        probe("R8", 4, 0, 0);
        do_cmp(2'b01, 0, 0, 4, 2);
        tick(); idle();
        probe("R8", 4, 0, 0);
        tick();
        probe("R8", 4, 0, 0);
        tick();
        probe("R8", 4, 0, 1);
    endtask

    task automatic t_counters();
        do_exec(1, 2'b01, 2'b00, 0, 5);
        tick(); idle();
        q_valid = 1; set_op(0, 1, 0, 0, 1); set_op(1, 1, 1, 0, 5); set_op(2, 1, 0, 0, 5);
        #1 chk("R2", "blocked query ready", int'(q_ready), 0);
        tick();
        chk("R4", "wax after dst block", int'(wax_cnt), 1);
        chk("R4", "raw after dst block", int'(raw_cnt), 0);
        q_vec = '0; set_op(0, 1, 0, 0, 5);
        tick();
        chk("R4", "raw after src block", int'(raw_cnt), 1);
        q_vec = '0; set_op(0, 0, 0, 0, 5); set_op(1, 1, 0, 0, 3);
        #1 chk("R2", "non-vector operand ready", int'(q_ready), 1);
        tick();
        chk("R4", "raw unchanged when ready", int'(raw_cnt), 1);
        q_vec = '0; set_op(0, 1, 0, 1, 4);
        tick();
        chk("R4", "raw after wide pair block", int'(raw_cnt), 2);
        chk("R4", "wax unchanged", int'(wax_cnt), 1);
        idle();
        do_cmp(2'b01, 0, 0, 5, 0);
        tick(); idle();
        tick();
        probe("R8", 5, 0, 1);
    endtask

    task automatic t_stall();
        do_exec(0, 2'b11, 2'b00, 2, 1);
        tick(); idle();
        do_exec(0, 2'b01, 2'b00, 0, 3);
        #1 chk("R9", "ex_stall when table full", int'(ex_stall), 1);
        do_cmp(2'b01, 0, 0, 6, 1);
        #1 chk("R11", "cmp_stall when table full", int'(cmp_stall), 1);
        tick(); idle();
        probe("R9", 3, 0, 1);
        do_exec(1, 2'b01, 2'b00, 0, 3);
        #1 chk("R9", "deferred never stalls", int'(ex_stall), 0);
        tick(); idle();
        probe("R9", 3, 0, 0);
        repeat (SP) tick();
        probe("R7", 1, 0, 1);
        // completion served first: it takes one slot, a two-dest execute then stalls
        do_cmp(2'b01, 0, 0, 3, 1);
        do_exec(0, 2'b11, 2'b00, 2, 1);
        #1 chk("R11", "completion accepted", int'(cmp_stall), 0);
        chk("R11", "execute stalls behind completion", int'(ex_stall), 1);
        tick(); idle();
        probe("R11", 1, 0, 1);
        tick();
        probe("R11", 3, 0, 1);
    endtask

    task automatic t_set_wins();
        do_exec(0, 2'b01, 2'b00, 0, 6);
        tick(); idle();
        repeat (SP-1) tick();
        do_exec(1, 2'b01, 2'b00, 0, 6);
        tick(); idle();
        probe("R10", 6, 0, 0);
        repeat (6) tick();
        probe("R10", 6, 0, 0);
        do_cmp(2'b01, 0, 0, 6, 1);
        tick(); idle();
        tick();
        probe("R10", 6, 0, 1);
    endtask

    initial begin
        idle();
        repeat (3) tick();
        rst = 0;
        tick();
        t_reset();
        t_issue_exec_narrow();
        t_wide_wrap();
        t_deferred();
        t_counters();
        t_stall();
        t_set_wins();
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                chk("WD", "watchdog expired", 1, 0);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule